// File: doc/BRIEF.md
# Clock-Trim Control and Status Register Bank

This block is the software-visible register bank for a frequency-error trim engine. It has four 32-bit words on a simple single-cycle bus: control, configuration, read-only status and write-one-to-clear. The control word holds four interrupt enables, the measurement counter enable, the automatic trim enable, a self-clearing software SYNC request and the oscillator trim value. The configuration word holds the counter reload value, the error limit, the SYNC divider, the SYNC source select and the SYNC polarity. All of these fields drive the engine directly through dedicated outputs.

The engine reports events as single-cycle pulses. The bank turns each pulse into a sticky flag and latches the captured error value and counting direction whenever the engine marks a capture. It also raises one interrupt line whenever an enabled flag is set. Two protections apply. The configuration word ignores writes while the counter runs. The trim field ignores software writes while automatic trimming is enabled, and during that time it follows values loaded by the engine.

Reads are combinational from the word selected by `addr_i[3:2]`. Writes take effect at the clock edge on which `wr_en_i` is high. Address bits 1:0 are ignored.

Top module: `clktrim_regbank`

## Requirements
- R1: After reset the control word (offset 0x0) reads 0x0000_2000, which is trim 32 with every other field 0. The configuration (0x4) and status (0x8) words read 0, and `irq_o` is low.
- R2: Control word layout: bits 3:0 are interrupt enables (bit 0 OK, bit 1 warning, bit 2 error, bit 3 expected-SYNC), bit 5 is the counter enable, bit 6 is the auto-trim enable and bits 13:8 are the trim value. All other bits read 0. The fields appear on the matching outputs in the cycle after the write.
- R3: Configuration word layout: bits 15:0 reload, 23:16 limit, 26:24 divider, 29:28 source and 31 polarity. Other bits read 0. A write to 0x4 is ignored while the counter enable is 1.
- R4: Writing 1 to control bit 7 drives `swsync_o` high for exactly one cycle, in the cycle after the write. Bit 7 reads 0 afterwards.
- R5: While auto-trim is 1, software writes to the trim field are ignored, and a cycle with `hw_trim_valid_i` high loads `hw_trim_i` into it. While auto-trim is 0, `hw_trim_valid_i` has no effect.
- R6: Status word layout: bit 0 OK, 1 warning, 2 error, 3 expected-SYNC, 8 SYNC error, 9 SYNC missed, 10 trim overflow, 15 direction, 31:16 captured error. An event pulse sets its flag from the next cycle on, and the flag stays set until it is cleared.
- R7: Status bit 2 is 1 exactly when at least one of bits 8, 9 or 10 is 1.
- R8: Writing to 0x0C clears flags as follows: bit 0 clears OK, bit 1 clears warning, bit 3 clears expected-SYNC, and bit 2 clears SYNC error, SYNC missed and trim overflow together. Bits written as 0 leave their flags unchanged.
- R9: If an event pulse and the clear of the same flag occur in the same cycle, the flag ends up set.
- R10: `irq_o` is high exactly when some status bit n (n = 0 to 3) is 1 while control bit n is also 1.
- R11: Writes to the status word (0x8) have no effect.
- R12: A cycle with `cap_valid_i` high latches `cap_dir_i` and `cap_value_i` into status bits 15 and 31:16. These bits hold their value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Byte address; bits 3:2 select the word |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the selected word |
| ev_ok_i | input | 1 | Pulse: measurement within the fine limit |
| ev_warn_i | input | 1 | Pulse: measurement needs a coarse correction |
| ev_expect_i | input | 1 | Pulse: counter reached zero |
| ev_syncerr_i | input | 1 | Pulse: error too large, SYNC came early |
| ev_miss_i | input | 1 | Pulse: SYNC missed |
| ev_trimovf_i | input | 1 | Pulse: trim adjustment out of range |
| cap_valid_i | input | 1 | Capture strobe |
| cap_dir_i | input | 1 | Counting direction at capture |
| cap_value_i | input | 16 | Counter value at capture |
| hw_trim_valid_i | input | 1 | Engine trim load strobe |
| hw_trim_i | input | 6 | Engine trim value |
| cnt_en_o | output | 1 | Counter enable |
| autotrim_o | output | 1 | Auto-trim enable |
| swsync_o | output | 1 | Software SYNC pulse |
| trim_o | output | 6 | Current trim value |
| reload_o | output | 16 | Counter reload value |
| felim_o | output | 8 | Error limit |
| syncdiv_o | output | 3 | SYNC divider select |
| syncsrc_o | output | 2 | SYNC source select |
| syncpol_o | output | 1 | SYNC polarity |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions check several rules on every cycle: the configuration is held while the counter runs, the trim value is held under auto-trim when no engine load is present, the software SYNC pulse clears itself, every flag is sticky, a set wins over a simultaneous clear, the capture is held, and the interrupt stays quiet when no flag is set. Other behaviour only the bench scenarios can show. These are the bit positions of every field, the reserved bits reading 0, the mapping from each clear bit to its flags, the error flag aggregating its three sources, and the interrupt following each enable and flag pairing as registers are rewritten.

// File: rtl/clktrim_pkg.sv
package clktrim_pkg;

    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 32;
    localparam int IE_W     = 4;
    localparam int TRIM_W   = 6;
    localparam int RELOAD_W = 16;
    localparam int FELIM_W  = 8;
    localparam int DIV_W    = 3;
    localparam int SRC_W    = 2;
    localparam int CAP_W    = 16;
    localparam int NFLAG    = 6;

    // word select (addr bits 3:2)
    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_CFG  = 2'd1;
    localparam logic [1:0] SEL_STAT = 2'd2;
    localparam logic [1:0] SEL_CLR  = 2'd3;

    // sticky flag indices
    localparam int F_OK   = 0;
    localparam int F_WARN = 1;
    localparam int F_EXP  = 2;
    localparam int F_SERR = 3;
    localparam int F_MISS = 4;
    localparam int F_TOVF = 5;

    typedef struct packed {
        logic [IE_W-1:0]   ie;
        logic              cnt_en;
        logic              autotrim;
        logic              swsync;
        logic [TRIM_W-1:0] trim;
    } ctrl_t;

    typedef struct packed {
        logic [RELOAD_W-1:0] reload;
        logic [FELIM_W-1:0]  felim;
        logic [DIV_W-1:0]    div;
        logic [SRC_W-1:0]    src;
        logic                pol;
    } cfg_t;

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w         = '0;
        w[3:0]    = c.ie;
        w[5]      = c.cnt_en;
        w[6]      = c.autotrim;
        w[7]      = c.swsync;
        w[13:8]   = c.trim;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] pack_cfg(input cfg_t c);
        logic [DATA_W-1:0] w;
        w         = '0;
        w[15:0]   = c.reload;
        w[23:16]  = c.felim;
        w[26:24]  = c.div;
        w[29:28]  = c.src;
        w[31]     = c.pol;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] pack_status(input logic [NFLAG-1:0] f,
                                                      input logic dir,
                                                      input logic [CAP_W-1:0] cap);
        logic [DATA_W-1:0] w;
        w         = '0;
        w[0]      = f[F_OK];
        w[1]      = f[F_WARN];
        w[2]      = f[F_SERR] | f[F_MISS] | f[F_TOVF];
        w[3]      = f[F_EXP];
        w[8]      = f[F_SERR];
        w[9]      = f[F_MISS];
        w[10]     = f[F_TOVF];
        w[15]     = dir;
        w[31:16]  = cap;
        return w;
    endfunction

endpackage

// File: rtl/clktrim_ctrl_regs.sv
module clktrim_ctrl_regs
    import clktrim_pkg::*;
#(
    parameter logic [TRIM_W-1:0] TRIM_RST = 6'd32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl_i,
    input  logic              wr_cfg_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              hw_trim_valid_i,
    input  logic [TRIM_W-1:0] hw_trim_i,
    output ctrl_t             ctrl_o,
    output cfg_t              cfg_o
);

    typedef struct packed {
        ctrl_t ctrl;
        cfg_t  cfg;
    } state_t;

    localparam state_t RST_STATE = '{
        ctrl: '{ie: '0, cnt_en: 1'b0, autotrim: 1'b0, swsync: 1'b0, trim: TRIM_RST},
        cfg:  '{reload: '0, felim: '0, div: '0, src: '0, pol: 1'b0}
    };

    state_t s_d, s_q;

    logic [1:0] unused_wbits;
    assign unused_wbits = {wdata_i[30], wdata_i[27]};

    always_comb begin
        s_d = s_q;
        s_d.ctrl.swsync = 1'b0;
        if (wr_ctrl_i) begin
            s_d.ctrl.ie       = wdata_i[3:0];
            s_d.ctrl.cnt_en   = wdata_i[5];
            s_d.ctrl.autotrim = wdata_i[6];
            s_d.ctrl.swsync   = wdata_i[7];
            if (!s_q.ctrl.autotrim) begin
                s_d.ctrl.trim = wdata_i[13:8];
            end
        end
        if (s_q.ctrl.autotrim && hw_trim_valid_i) begin
            s_d.ctrl.trim = hw_trim_i;
        end
        if (wr_cfg_i && !s_q.ctrl.cnt_en) begin
            s_d.cfg.reload = wdata_i[15:0];
            s_d.cfg.felim  = wdata_i[23:16];
            s_d.cfg.div    = wdata_i[26:24];
            s_d.cfg.src    = wdata_i[29:28];
            s_d.cfg.pol    = wdata_i[31];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= RST_STATE;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctrl_o = s_q.ctrl;
    assign cfg_o  = s_q.cfg;

    // R3: configuration frozen while the counter runs
    p_cfg_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cfg_i && s_q.ctrl.cnt_en) |=> $stable(s_q.cfg));

    // R4: the software SYNC request lasts a single cycle
    p_swsync_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ctrl.swsync && !wr_ctrl_i) |=> !s_q.ctrl.swsync);

    // R5: trim held under auto-trim unless the engine loads it
    p_trim_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ctrl.autotrim && !hw_trim_valid_i) |=> $stable(s_q.ctrl.trim));

endmodule

// File: rtl/clktrim_flag_unit.sv
module clktrim_flag_unit
    import clktrim_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_i,
    input  logic [NFLAG-1:0] clr_i,
    input  logic             cap_valid_i,
    input  logic             cap_dir_i,
    input  logic [CAP_W-1:0] cap_value_i,
    output logic [NFLAG-1:0] flags_o,
    output logic             dir_o,
    output logic [CAP_W-1:0] cap_o
);

    typedef struct packed {
        logic [NFLAG-1:0] flags;
        logic             dir;
        logic [CAP_W-1:0] cap;
    } fstate_t;

    fstate_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        for (int i = 0; i < NFLAG; i++) begin
            // a set in the same cycle overrides a clear
            f_d.flags[i] = set_i[i] | (f_q.flags[i] & ~clr_i[i]);
        end
        if (cap_valid_i) begin
            f_d.dir = cap_dir_i;
            f_d.cap = cap_value_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign flags_o = f_q.flags;
    assign dir_o   = f_q.dir;
    assign cap_o   = f_q.cap;

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag_chk
        // R6: a flag stays set until a clear targets it
        p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (f_q.flags[g] && !clr_i[g]) |=> f_q.flags[g]);
        // R9: set beats clear
        p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> f_q.flags[g]);
    end

    // R12: capture held without a strobe
    p_cap_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_valid_i |=> ($stable(f_q.cap) && $stable(f_q.dir)));

endmodule

// File: rtl/clktrim_regbank.sv
module clktrim_regbank
    import clktrim_pkg::*;
#(
    parameter logic [TRIM_W-1:0] TRIM_RST = 6'd32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                wr_en_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [DATA_W-1:0]   rdata_o,
    input  logic                ev_ok_i,
    input  logic                ev_warn_i,
    input  logic                ev_expect_i,
    input  logic                ev_syncerr_i,
    input  logic                ev_miss_i,
    input  logic                ev_trimovf_i,
    input  logic                cap_valid_i,
    input  logic                cap_dir_i,
    input  logic [CAP_W-1:0]    cap_value_i,
    input  logic                hw_trim_valid_i,
    input  logic [TRIM_W-1:0]   hw_trim_i,
    output logic                cnt_en_o,
    output logic                autotrim_o,
    output logic                swsync_o,
    output logic [TRIM_W-1:0]   trim_o,
    output logic [RELOAD_W-1:0] reload_o,
    output logic [FELIM_W-1:0]  felim_o,
    output logic [DIV_W-1:0]    syncdiv_o,
    output logic [SRC_W-1:0]    syncsrc_o,
    output logic                syncpol_o,
    output logic                irq_o
);

    logic [1:0]        sel;
    logic [1:0]        unused_addr;
    logic              wr_ctrl, wr_cfg, wr_clr;
    logic [NFLAG-1:0]  set_vec, clr_vec;
    logic [NFLAG-1:0]  flags;
    logic              cap_dir;
    logic [CAP_W-1:0]  cap_val;
    logic [DATA_W-1:0] status_w;
    logic [IE_W-1:0]   src_vec;
    ctrl_t             ctrl;
    cfg_t              cfg;

    assign sel         = addr_i[3:2];
    assign unused_addr = addr_i[1:0];
    assign wr_ctrl     = wr_en_i && (sel == SEL_CTRL);
    assign wr_cfg      = wr_en_i && (sel == SEL_CFG);
    assign wr_clr      = wr_en_i && (sel == SEL_CLR);

    always_comb begin
        set_vec          = '0;
        set_vec[F_OK]    = ev_ok_i;
        set_vec[F_WARN]  = ev_warn_i;
        set_vec[F_EXP]   = ev_expect_i;
        set_vec[F_SERR]  = ev_syncerr_i;
        set_vec[F_MISS]  = ev_miss_i;
        set_vec[F_TOVF]  = ev_trimovf_i;
        clr_vec          = '0;
        clr_vec[F_OK]    = wr_clr & wdata_i[0];
        clr_vec[F_WARN]  = wr_clr & wdata_i[1];
        clr_vec[F_EXP]   = wr_clr & wdata_i[3];
        clr_vec[F_SERR]  = wr_clr & wdata_i[2];
        clr_vec[F_MISS]  = wr_clr & wdata_i[2];
        clr_vec[F_TOVF]  = wr_clr & wdata_i[2];
    end

    clktrim_ctrl_regs #(.TRIM_RST(TRIM_RST)) ctrl_regs_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .wr_ctrl_i       (wr_ctrl),
        .wr_cfg_i        (wr_cfg),
        .wdata_i         (wdata_i),
        .hw_trim_valid_i (hw_trim_valid_i),
        .hw_trim_i       (hw_trim_i),
        .ctrl_o          (ctrl),
        .cfg_o           (cfg)
    );

    clktrim_flag_unit flag_unit_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (set_vec),
        .clr_i       (clr_vec),
        .cap_valid_i (cap_valid_i),
        .cap_dir_i   (cap_dir_i),
        .cap_value_i (cap_value_i),
        .flags_o     (flags),
        .dir_o       (cap_dir),
        .cap_o       (cap_val)
    );

    assign status_w = pack_status(flags, cap_dir, cap_val);

    always_comb begin
        unique case (sel)
            SEL_CTRL: rdata_o = pack_ctrl(ctrl);
            SEL_CFG:  rdata_o = pack_cfg(cfg);
            SEL_STAT: rdata_o = status_w;
            default:  rdata_o = '0;
        endcase
    end

    // interrupt sources in enable-bit order
    assign src_vec = status_w[3:0];
    assign irq_o   = |(src_vec & ctrl.ie);

    assign cnt_en_o   = ctrl.cnt_en;
    assign autotrim_o = ctrl.autotrim;
    assign swsync_o   = ctrl.swsync;
    assign trim_o     = ctrl.trim;
    assign reload_o   = cfg.reload;
    assign felim_o    = cfg.felim;
    assign syncdiv_o  = cfg.div;
    assign syncsrc_o  = cfg.src;
    assign syncpol_o  = cfg.pol;

    // R10: no flag, no interrupt
    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == '0) |-> !irq_o);

    // R7: any error source with the error enable raises the interrupt
    p_err_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags[F_SERR] | flags[F_MISS] | flags[F_TOVF]) && ctrl.ie[2]) |-> irq_o);

endmodule

// File: tb/clktrim_regbank_tb.sv
`timescale 1ns/1ps
module clktrim_regbank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [5:0]  ev = '0;
    logic        cap_valid = 1'b0;
    logic        cap_dir = 1'b0;
    logic [15:0] cap_value = '0;
    logic        hw_trim_valid = 1'b0;
    logic [5:0]  hw_trim = '0;
    logic        cnt_en, autotrim, swsync, syncpol, irq;
    logic [5:0]  trim;
    logic [15:0] reload;
    logic [7:0]  felim;
    logic [2:0]  syncdiv;
    logic [1:0]  syncsrc;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    clktrim_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata),
        .rdata_o(rdata),
        .ev_ok_i(ev[0]), .ev_warn_i(ev[1]), .ev_expect_i(ev[2]),
        .ev_syncerr_i(ev[3]), .ev_miss_i(ev[4]), .ev_trimovf_i(ev[5]),
        .cap_valid_i(cap_valid), .cap_dir_i(cap_dir), .cap_value_i(cap_value),
        .hw_trim_valid_i(hw_trim_valid), .hw_trim_i(hw_trim),
        .cnt_en_o(cnt_en), .autotrim_o(autotrim), .swsync_o(swsync), .trim_o(trim),
        .reload_o(reload), .felim_o(felim), .syncdiv_o(syncdiv), .syncsrc_o(syncsrc),
        .syncpol_o(syncpol), .irq_o(irq)
    );

    // event bit order in ev: 0 ok, 1 warn, 2 expect, 3 syncerr, 4 miss, 5 trimovf
    localparam logic [5:0] E_OK = 6'h01, E_WARN = 6'h02, E_EXP = 6'h04,
                           E_SERR = 6'h08, E_MISS = 6'h10, E_TOVF = 6'h20;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic check_rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        check(tag, rdata, exp);
    endtask

    task automatic pulse_ev(input logic [5:0] e);
        @(negedge clk);
        ev = e;
        @(negedge clk);
        ev = '0;
    endtask

    task automatic t_reset();
        check_rd("R1 ctrl reset", 4'h0, 32'h0000_2000);
        check_rd("R1 cfg reset", 4'h4, 32'h0);
        check_rd("R1 status reset", 4'h8, 32'h0);
        check("R1 irq reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_ctrl_fields();
        bus_wr(4'h0, 32'hAAAA_2A1A);
        check_rd("R2 ctrl readback", 4'h0, 32'h0000_2A0A);
        check("R2 trim_o", {26'b0, trim}, 32'h2A);
        check("R2 cnt_en_o", {31'b0, cnt_en}, 32'h0);
        bus_wr(4'h0, 32'h0000_2000);
    endtask

    task automatic t_autotrim();
        bus_wr(4'h0, 32'h0000_1040);
        check_rd("R5 autotrim on", 4'h0, 32'h0000_1040);
        check("R5 autotrim_o", {31'b0, autotrim}, 32'h1);
        bus_wr(4'h0, 32'h0000_3F40);
        check_rd("R5 sw trim ignored", 4'h0, 32'h0000_1040);
        @(negedge clk);
        hw_trim_valid = 1'b1; hw_trim = 6'h07;
        @(negedge clk);
        hw_trim_valid = 1'b0;
        check_rd("R5 hw trim loaded", 4'h0, 32'h0000_0740);
        check("R5 trim_o hw", {26'b0, trim}, 32'h07);
        bus_wr(4'h0, 32'h0000_2000);
        check_rd("R5 trim kept on disable write", 4'h0, 32'h0000_0700);
        @(negedge clk);
        hw_trim_valid = 1'b1; hw_trim = 6'h03;
        @(negedge clk);
        hw_trim_valid = 1'b0;
        check_rd("R5 hw trim ignored when off", 4'h0, 32'h0000_0700);
        bus_wr(4'h0, 32'h0000_2000);
        check_rd("R5 sw trim restored", 4'h0, 32'h0000_2000);
    endtask

    task automatic t_config();
        bus_wr(4'h4, 32'hFFAB_1234);
        check_rd("R3 cfg readback", 4'h4, 32'hB7AB_1234);
        check("R3 reload_o", {16'b0, reload}, 32'h1234);
        check("R3 fields", {16'b0, felim, 2'b0, syncdiv, syncsrc, syncpol}, {16'b0, 8'hAB, 2'b0, 3'h7, 2'h3, 1'b1});
        bus_wr(4'h0, 32'h0000_2020);
        check("R3 cnt_en_o", {31'b0, cnt_en}, 32'h1);
        bus_wr(4'h4, 32'h0000_0001);
        check_rd("R3 cfg locked", 4'h4, 32'hB7AB_1234);
        bus_wr(4'h0, 32'h0000_2000);
        bus_wr(4'h4, 32'h0000_0055);
        check_rd("R3 cfg unlocked", 4'h4, 32'h0000_0055);
    endtask

    task automatic t_swsync();
        check("R4 swsync idle", {31'b0, swsync}, 32'h0);
        bus_wr(4'h0, 32'h0000_2080);
        check("R4 swsync pulse", {31'b0, swsync}, 32'h1);
        @(negedge clk);
        check("R4 swsync self-clear", {31'b0, swsync}, 32'h0);
        check_rd("R4 bit7 reads 0", 4'h0, 32'h0000_2000);
    endtask

    task automatic t_flags();
        pulse_ev(E_OK);
        check_rd("R6 ok flag", 4'h8, 32'h0000_0001);
        pulse_ev(E_WARN);
        check_rd("R6 warn flag", 4'h8, 32'h0000_0003);
        pulse_ev(E_EXP);
        check_rd("R6 expect flag", 4'h8, 32'h0000_000B);
        pulse_ev(E_SERR);
        check_rd("R7 syncerr sets err", 4'h8, 32'h0000_010F);
        bus_wr(4'hC, 32'h0000_000F);
        check_rd("R8 clear all", 4'h8, 32'h0);
        pulse_ev(E_MISS);
        check_rd("R7 miss sets err", 4'h8, 32'h0000_0204);
        pulse_ev(E_TOVF);
        check_rd("R7 trimovf adds", 4'h8, 32'h0000_0604);
        bus_wr(4'hC, 32'h0000_0002);
        check_rd("R8 warn clear leaves errors", 4'h8, 32'h0000_0604);
        bus_wr(4'hC, 32'h0000_0004);
        check_rd("R8 err clear all three", 4'h8, 32'h0);
    endtask

    task automatic t_clear_map();
        pulse_ev(E_OK | E_WARN | E_EXP);
        check_rd("R8 setup", 4'h8, 32'h0000_000B);
        bus_wr(4'hC, 32'h0000_0001);
        check_rd("R8 clear ok", 4'h8, 32'h0000_000A);
        bus_wr(4'hC, 32'h0000_0008);
        check_rd("R8 clear expect", 4'h8, 32'h0000_0002);
        bus_wr(4'hC, 32'h0000_0000);
        check_rd("R8 zero write no effect", 4'h8, 32'h0000_0002);
        bus_wr(4'hC, 32'h0000_0002);
        check_rd("R8 clear warn", 4'h8, 32'h0);
    endtask

    task automatic t_set_wins();
        @(negedge clk);
        ev = E_EXP; addr = 4'hC; wdata = 32'h8; wr_en = 1'b1;
        @(negedge clk);
        ev = '0; wr_en = 1'b0; wdata = '0;
        check_rd("R9 set beats clear", 4'h8, 32'h0000_0008);
        bus_wr(4'hC, 32'h0000_0008);
        check_rd("R9 cleanup", 4'h8, 32'h0);
    endtask

    task automatic t_status_ro();
        bus_wr(4'h8, 32'hFFFF_FFFF);
        check_rd("R11 status write ignored", 4'h8, 32'h0);
        check_rd("R11 ctrl untouched", 4'h0, 32'h0000_2000);
        check("R11 irq low", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_irq();
        bus_wr(4'h0, 32'h0000_200F);
        check("R10 no flags no irq", {31'b0, irq}, 32'h0);
        bus_wr(4'h0, 32'h0000_2000);
        pulse_ev(E_OK);
        check("R10 flag without enable", {31'b0, irq}, 32'h0);
        bus_wr(4'h0, 32'h0000_2001);
        check("R10 ok enable", {31'b0, irq}, 32'h1);
        bus_wr(4'hC, 32'h0000_0001);
        check("R10 cleared drops irq", {31'b0, irq}, 32'h0);
        pulse_ev(E_MISS);
        bus_wr(4'h0, 32'h0000_2004);
        check("R10 err enable", {31'b0, irq}, 32'h1);
        bus_wr(4'h0, 32'h0000_2001);
        check("R10 wrong enable", {31'b0, irq}, 32'h0);
        bus_wr(4'hC, 32'h0000_0004);
        bus_wr(4'h0, 32'h0000_2000);
    endtask

    task automatic t_capture();
        @(negedge clk);
        cap_valid = 1'b1; cap_dir = 1'b1; cap_value = 16'hBEEF;
        @(negedge clk);
        cap_valid = 1'b0; cap_dir = 1'b0; cap_value = 16'h1111;
        check_rd("R12 capture latched", 4'h8, 32'hBEEF_8000);
        repeat (3) @(negedge clk);
        check_rd("R12 capture held", 4'h8, 32'hBEEF_8000);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl_fields();
        t_autotrim();
        t_config();
        t_swsync();
        t_flags();
        t_clear_map();
        t_set_wins();
        t_status_ro();
        t_irq();
        t_capture();
        finish_run();
    end

endmodule